// File: doc/BRIEF.md
# DMA Source-Destination Packing Engine

A single-channel data mover that copies a programmed number of bytes from a source region to a destination region. Each side has its own transfer size: byte, 16-bit word, 32-bit longword, or a 16-byte line moved as four 32-bit beats. Bytes read from the source collect in a 16-byte staging buffer, in the order they arrive. A destination write starts only when the buffer holds one complete destination transfer. This lets the engine read narrow and write wide, or read wide and write narrow.

The engine uses a 32-bit request/grant memory port with byte enables. A grant completes the access in the same cycle, with read data and an error flag valid alongside it. Every beat of a line transfer carries a lock flag, so the four beats go out as one indivisible unit. Four sticky status bits report completion, bus fault, misaligned start and bad configuration. Each bit has its own enable, and together they drive one interrupt line.

Top module: `dma_pack_engine`

## Requirements
- R1: Size code per side: 2'b00 = 4-byte longword, 2'b01 = 1 byte, 2'b10 = 2-byte word, 2'b11 = 16-byte line (four 4-byte beats). After each complete transfer the pointer on that side advances by 4, 1, 2 or 16 bytes. On completion `src_ptr_o` equals the start source address plus the count, and `dst_ptr_o` equals the start destination address plus the count. The number of granted source reads is the count divided by the per-beat width (4 for a line).
- R2: No destination write is issued until the buffer holds one destination transfer. The number of source beats before the first write is max(S,D)/b, where S and D are the transfer sizes and b is the source beat width.
- R3: Bytes are packed little-endian in arrival order. After completion the destination bytes equal the source bytes over the count, and no byte beyond the count is written.
- R4: A line transfer is four consecutive granted beats at addresses base, +4, +8, +12, each with `mem_lock_o` high. While a request waits for its grant, its address and direction are held.
- R5: Choosing the line size for a side whose line-capable flag (`src_line_ok_i` / `dst_line_ok_i`) is low sets status bit 3 (bad configuration). No memory access is made.
- R6: A start with a zero count, or with a count that is not a multiple of the larger of the two transfer sizes, sets status bit 3. No memory access is made.
- R7: A start address not aligned to its own side's transfer size sets status bit 2 (misaligned), unless bit 3 applies. No memory access is made.
- R8: An error reply on any granted access stops the transfer and sets status bit 1. `busy_o` drops, and both pointers are left at the failing access: a source pointer that has already advanced past a completed read stays advanced.
- R9: A completed transfer sets status bit 0 on the same edge that `busy_o` falls. The staging buffer is empty at that point.
- R10: `irq_o` is high exactly when some status bit and its matching `irq_en_i` bit are both set.
- R11: Writing 1 to a `stat_clr_i` bit clears that status bit. A 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R12: After reset, the status bits, `busy_o`, `mem_req_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_addr_i | input | ADDR_W | Source start address |
| dst_addr_i | input | ADDR_W | Destination start address |
| byte_cnt_i | input | CNT_W | Bytes to move |
| src_size_i | input | 2 | Source size code |
| dst_size_i | input | 2 | Destination size code |
| src_line_ok_i | input | 1 | Source region accepts line transfers |
| dst_line_ok_i | input | 1 | Destination region accepts line transfers |
| irq_en_i | input | 4 | Per-status interrupt enables |
| stat_clr_i | input | 4 | Write-1-to-clear strobes for the status bits |
| status_o | output | 4 | Bit 0 done, 1 bus fault, 2 misaligned, 3 bad configuration |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Transfer in progress |
| src_ptr_o | output | ADDR_W | Current source pointer |
| dst_ptr_o | output | ADDR_W | Current destination pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_lock_o | output | 1 | Beat belongs to an indivisible line |
| mem_addr_o | output | ADDR_W | Access address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Grant; completes the access this cycle |
| mem_err_i | input | 1 | Error reply, valid with the grant |
| mem_rdata_i | input | 32 | Read data, valid with the grant |

## Verification
A rejected start (bad configuration or misalignment) shows in `status_o` one edge after the `start_i` pulse, with `busy_o` never rising. The done and fault bits appear on the same edge as the final or failing grant, together with the fall of `busy_o`. The bench therefore samples all of these at the falling edge that follows. `irq_o` is combinational from status and enables, so it is read a small delay after the enables change. A clear strobe takes effect one edge later. The memory model grants two cycles in three, which makes stalled requests and held locks occur in every transfer.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} fsm_e;

  localparam int unsigned NUM_ST = 4;
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_FLT  = 1;
  localparam int unsigned ST_ALN  = 2;
  localparam int unsigned ST_CFG  = 3;

  function automatic logic [4:0] size_bytes(input xfer_size_e s);
    case (s)
      SZ_BYTE: return 5'd1;
      SZ_WORD: return 5'd2;
      SZ_LINE: return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_bytes(input xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] byte_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_pack_cfg_chk.sv
module dma_pack_cfg_chk
  import dma_pack_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  xfer_size_e       src_size_i,
  input  xfer_size_e       dst_size_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [3:0]       src_lsb_i,
  input  logic [3:0]       dst_lsb_i,
  input  logic             src_line_ok_i,
  input  logic             dst_line_ok_i,
  output logic             bad_cfg_o,
  output logic             misalign_o
);
  logic [4:0] s_sz, d_sz, big_sz;
  logic [3:0] big_m, s_m, d_m;

  always_comb begin
    s_sz   = size_bytes(src_size_i);
    d_sz   = size_bytes(dst_size_i);
    big_sz = (s_sz > d_sz) ? s_sz : d_sz;
    big_m  = 4'(big_sz - 5'd1);
    s_m    = 4'(s_sz - 5'd1);
    d_m    = 4'(d_sz - 5'd1);
    bad_cfg_o = ((src_size_i == SZ_LINE) && !src_line_ok_i) ||
                ((dst_size_i == SZ_LINE) && !dst_line_ok_i) ||
                (cnt_i == '0) || ((cnt_i[3:0] & big_m) != 4'd0);
    misalign_o = ((src_lsb_i & s_m) != 4'd0) || ((dst_lsb_i & d_m) != 4'd0);
  end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf
  import dma_pack_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [2:0]       push_n_i,
  input  logic [31:0]      push_data_i,
  input  logic             pop_i,
  input  logic [2:0]       pop_n_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [31:0]      head_o
);
  localparam int unsigned BW = 8 * DEPTH;

  logic [BW-1:0]    data_q;
  logic [LVL_W-1:0] lvl_q;
  logic [BW-1:0]    ins;

  // new bytes land just above the current fill, lower bytes leave first
  assign ins = BW'(push_data_i & byte_mask(push_n_i)) << {lvl_q, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      lvl_q  <= '0;
    end else if (flush_i) begin
      data_q <= '0;
      lvl_q  <= '0;
    end else if (pop_i) begin
      data_q <= data_q >> {pop_n_i, 3'b000};
      lvl_q  <= lvl_q - LVL_W'(pop_n_i);
    end else if (push_i) begin
      data_q <= data_q | ins;
      lvl_q  <= lvl_q + LVL_W'(push_n_i);
    end
  end

  assign lvl_o  = lvl_q;
  assign head_o = data_q[31:0];
endmodule

// File: rtl/dma_pack_status.sv
module dma_pack_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & en_i);
endmodule

// File: rtl/dma_pack_engine.sv
module dma_pack_engine
  import dma_pack_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BUF_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [1:0]        src_size_i,
  input  logic [1:0]        dst_size_i,
  input  logic              src_line_ok_i,
  input  logic              dst_line_ok_i,
  input  logic [3:0]        irq_en_i,
  input  logic [3:0]        stat_clr_i,
  output logic [3:0]        status_o,
  output logic              irq_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] src_ptr_o,
  output logic [ADDR_W-1:0] dst_ptr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned LVL_W = $clog2(BUF_BYTES + 1);
  localparam int unsigned XW    = LVL_W + 1;

  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [1:0]        beat_q, beat_d;
  xfer_size_e        ss_q, ss_d, ds_q, ds_d;
  logic [NUM_ST-1:0] st_set;

  logic              bad_cfg, misalign;
  logic [LVL_W-1:0]  lvl;
  logic [31:0]       head, push_data;
  logic [4:0]        s_xfer, d_xfer;
  logic [2:0]        s_beat, d_beat, cur_beat;
  logic              rd_phase, is_line, last_beat, acc_ok, acc_err;
  logic [XW-1:0]     lvl_push, lvl_pop;
  logic [1:0]        lane;

  dma_pack_cfg_chk #(.CNT_W(CNT_W)) u_cfg (
    .src_size_i   (xfer_size_e'(src_size_i)),
    .dst_size_i   (xfer_size_e'(dst_size_i)),
    .cnt_i        (byte_cnt_i),
    .src_lsb_i    (src_addr_i[3:0]),
    .dst_lsb_i    (dst_addr_i[3:0]),
    .src_line_ok_i(src_line_ok_i),
    .dst_line_ok_i(dst_line_ok_i),
    .bad_cfg_o    (bad_cfg),
    .misalign_o   (misalign)
  );

  dma_pack_buf #(.DEPTH(BUF_BYTES), .LVL_W(LVL_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (acc_err),
    .push_i     (rd_phase && acc_ok),
    .push_n_i   (s_beat),
    .push_data_i(push_data),
    .pop_i      ((state_q == S_WR) && acc_ok),
    .pop_n_i    (d_beat),
    .lvl_o      (lvl),
    .head_o     (head)
  );

  dma_pack_status #(.N(NUM_ST)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (st_set),
    .clr_i   (stat_clr_i),
    .en_i    (irq_en_i),
    .status_o(status_o),
    .irq_o   (irq_o)
  );

  always_comb begin
    s_xfer    = size_bytes(ss_q);
    d_xfer    = size_bytes(ds_q);
    s_beat    = beat_bytes(ss_q);
    d_beat    = beat_bytes(ds_q);
    rd_phase  = (state_q == S_RD);
    is_line   = rd_phase ? (ss_q == SZ_LINE) : (ds_q == SZ_LINE);
    cur_beat  = rd_phase ? s_beat : d_beat;
    mem_req_o = (state_q != S_IDLE);
    mem_we_o  = (state_q == S_WR);
    mem_lock_o = mem_req_o && is_line;
    mem_addr_o = (rd_phase ? src_q : dst_q) + ADDR_W'({beat_q, 2'b00});
    lane       = mem_addr_o[1:0];
    mem_be_o   = lane_mask(cur_beat) << lane;
    mem_wdata_o = (head & byte_mask(d_beat)) << {lane, 3'b000};
    push_data  = mem_rdata_i >> {lane, 3'b000};
    acc_ok     = mem_req_o && mem_gnt_i && !mem_err_i;
    acc_err    = mem_req_o && mem_gnt_i && mem_err_i;
    last_beat  = !is_line || (beat_q == 2'd3);
    lvl_push   = XW'(lvl) + XW'(s_beat);
    lvl_pop    = XW'(lvl) - XW'(d_beat);
  end

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    beat_d  = beat_q;
    ss_d    = ss_q;
    ds_d    = ds_q;
    st_set  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        if (bad_cfg)       st_set[ST_CFG] = 1'b1;
        else if (misalign) st_set[ST_ALN] = 1'b1;
        else begin
          src_d   = src_addr_i;
          dst_d   = dst_addr_i;
          rem_d   = byte_cnt_i;
          ss_d    = xfer_size_e'(src_size_i);
          ds_d    = xfer_size_e'(dst_size_i);
          beat_d  = '0;
          state_d = S_RD;
        end
      end
      S_RD: if (acc_err) begin
        st_set[ST_FLT] = 1'b1;
        beat_d  = '0;
        state_d = S_IDLE;
      end else if (acc_ok) begin
        if (last_beat) begin
          beat_d = '0;
          src_d  = src_q + ADDR_W'(s_xfer);
          rem_d  = rem_q - CNT_W'(s_xfer);
          if (lvl_push >= XW'(d_xfer)) state_d = S_WR;
        end else beat_d = beat_q + 2'd1;
      end
      S_WR: if (acc_err) begin
        st_set[ST_FLT] = 1'b1;
        beat_d  = '0;
        state_d = S_IDLE;
      end else if (acc_ok) begin
        if (last_beat) begin
          beat_d = '0;
          dst_d  = dst_q + ADDR_W'(d_xfer);
          if (lvl_pop < XW'(d_xfer)) begin
            if (rem_q != '0) state_d = S_RD;
            else begin
              state_d = S_IDLE;
              st_set[ST_DONE] = 1'b1;
            end
          end
        end else beat_d = beat_q + 2'd1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      beat_q  <= '0;
      ss_q    <= SZ_LONG;
      ds_q    <= SZ_LONG;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      beat_q  <= beat_d;
      ss_q    <= ss_d;
      ds_q    <= ds_d;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign src_ptr_o = src_q;
  assign dst_ptr_o = dst_q;
endmodule

// File: rtl/dma_pack_engine_chk.sv
module dma_pack_engine_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  byte_cnt_i,
  input logic              busy_o,
  input logic [3:0]        status_o,
  input logic [3:0]        stat_clr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_lock_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_gnt_i,
  input logic              mem_err_i
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_lock_o));

  // R4
  line_beat_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_lock_o && mem_gnt_i && !mem_err_i && (mem_addr_o[3:2] != 2'b11)
    |=> mem_req_o && mem_lock_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  // R8
  fault_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && mem_err_i |=> !busy_o && status_o[1]);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> !busy_o && !mem_req_o);

  // R6
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (byte_cnt_i == '0) |=> !busy_o && status_o[3]);

  // R11
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(stat_clr_i)) & ~status_o) == 4'd0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

bind dma_pack_engine dma_pack_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .byte_cnt_i(byte_cnt_i),
  .busy_o    (busy_o),
  .status_o  (status_o),
  .stat_clr_i(stat_clr_i),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_lock_o(mem_lock_o),
  .mem_addr_o(mem_addr_o),
  .mem_gnt_i (mem_gnt_i),
  .mem_err_i (mem_err_i)
);

// File: tb/dma_pack_engine_tb_top.sv
`timescale 1ns/1ps
module dma_pack_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0;
  logic [15:0] byte_cnt_i = '0;
  logic [1:0]  src_size_i = '0, dst_size_i = '0;
  logic        src_line_ok_i = 1'b1, dst_line_ok_i = 1'b1;
  logic [3:0]  irq_en_i = '0, stat_clr_i = '0;
  logic [3:0]  status_o;
  logic        irq_o, busy_o;
  logic [31:0] src_ptr_o, dst_ptr_o;
  logic        mem_req_o, mem_we_o, mem_lock_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic [3:0]  mem_be_o;
  logic        mem_gnt_i = 1'b0, mem_err_i = 1'b0;

  always #2 clk_i = ~clk_i;

  dma_pack_engine dut_i (.*);

  logic [7:0]  bmem [0:2047];
  int          n_chk = 0, n_err = 0;
  int          n_rd, n_wr, first_rd, lock_run, cyc = 0;
  bit          lock_bad, err_on = 1'b0;
  logic [31:0] err_addr = '0;

  // memory model: grants two cycles in three, data valid with grant
  always @(negedge clk_i) begin
    cyc = cyc + 1;
    mem_gnt_i = 1'b0;
    mem_err_i = 1'b0;
    if (mem_req_o && (cyc % 3 != 2)) begin
      mem_gnt_i = 1'b1;
      mem_err_i = err_on && (mem_addr_o == err_addr);
      mem_rdata_i = {bmem[{mem_addr_o[10:2], 2'd3}], bmem[{mem_addr_o[10:2], 2'd2}],
                     bmem[{mem_addr_o[10:2], 2'd1}], bmem[{mem_addr_o[10:2], 2'd0}]};
      if (!mem_err_i) begin
        if (mem_we_o) begin
          if (n_wr == 0) first_rd = n_rd;
          n_wr = n_wr + 1;
          for (int k = 0; k < 4; k++)
            if (mem_be_o[k]) bmem[{mem_addr_o[10:2], 2'(k)}] = mem_wdata_o[8*k +: 8];
        end else n_rd = n_rd + 1;
        if (mem_lock_o) lock_run = lock_run + 1;
        else if (lock_run % 4 != 0) lock_bad = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] ss, input logic [1:0] ds, input logic [15:0] cnt,
                     input logic [31:0] sa, input logic [31:0] da, input logic sok, input logic dok);
    @(negedge clk_i);
    n_rd = 0; n_wr = 0; first_rd = -1; lock_run = 0; lock_bad = 1'b0;
    src_size_i = ss; dst_size_i = ds; byte_cnt_i = cnt;
    src_addr_i = sa; dst_addr_i = da; src_line_ok_i = sok; dst_line_ok_i = dok;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int t = 0; t < 4000 && busy_o; t++) @(negedge clk_i);
  endtask

  task automatic clear_all();
    stat_clr_i = 4'hf;
    @(negedge clk_i);
    stat_clr_i = 4'h0;
  endtask

  function automatic int szb(input logic [1:0] c);
    case (c) 2'b01: return 1; 2'b10: return 2; 2'b11: return 16; default: return 4; endcase
  endfunction

  // {src size, dst size, byte count}
  localparam logic [19:0] VEC [13] = '{
    {2'b00, 2'b00, 16'd16}, {2'b01, 2'b00, 16'd8},  {2'b00, 2'b01, 16'd8},
    {2'b10, 2'b01, 16'd6},  {2'b01, 2'b10, 16'd6},  {2'b00, 2'b11, 16'd32},
    {2'b11, 2'b00, 16'd32}, {2'b11, 2'b11, 16'd32}, {2'b01, 2'b11, 16'd16},
    {2'b11, 2'b01, 16'd16}, {2'b10, 2'b11, 16'd16}, {2'b11, 2'b10, 16'd32},
    {2'b01, 2'b01, 16'd5}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) bmem[i] = 8'(i * 7 + 3);
    irq_en_i = 4'hf;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12", "status", {28'd0, status_o}, 32'd0);
    chk("R12", "busy", {31'd0, busy_o}, 32'd0);
    chk("R12", "req", {31'd0, mem_req_o}, 32'd0);
    chk("R12", "irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12", "status after release", {28'd0, status_o}, 32'd0);

    for (int v = 0; v < 13; v++) begin
      automatic logic [1:0]  ss = VEC[v][19:18];
      automatic logic [1:0]  ds = VEC[v][17:16];
      automatic logic [15:0] cnt = VEC[v][15:0];
      automatic int sb = (szb(ss) > 4) ? 4 : szb(ss);
      automatic int big = (szb(ss) > szb(ds)) ? szb(ss) : szb(ds);
      automatic int nlock = ((ss == 2'b11) ? int'(cnt) / 4 : 0) + ((ds == 2'b11) ? int'(cnt) / 4 : 0);
      automatic bit same = 1'b1;
      for (int i = 'h400; i < 'h480; i++) bmem[i] = 8'h00;
      run(ss, ds, cnt, 32'h100, 32'h400, 1'b1, 1'b1);
      chk("R9", "done status", {28'd0, status_o}, 32'h1);
      chk("R9", "busy after done", {31'd0, busy_o}, 32'd0);
      chk("R1", "src ptr", src_ptr_o, 32'h100 + 32'(cnt));
      chk("R1", "dst ptr", dst_ptr_o, 32'h400 + 32'(cnt));
      chk("R1", "read beats", n_rd, int'(cnt) / sb);
      chk("R2", "reads before first write", first_rd, big / sb);
      for (int i = 0; i < int'(cnt); i++) if (bmem['h400 + i] !== bmem['h100 + i]) same = 1'b0;
      chk("R3", "dst bytes match src", {31'd0, same}, 32'd1);
      chk("R3", "byte past end untouched", {24'd0, bmem['h400 + int'(cnt)]}, 32'd0);
      chk("R4", "locked beats", lock_run, nlock);
      chk("R4", "lock grouping", {31'd0, lock_bad}, 32'd0);
      clear_all();
    end

    // R5 line size without line-capable region
    run(2'b11, 2'b00, 16'd16, 32'h100, 32'h400, 1'b0, 1'b1);
    chk("R5", "src line bad cfg", {28'd0, status_o}, 32'h8);
    chk("R5", "no access", n_rd + n_wr, 0);
    clear_all();
    run(2'b00, 2'b11, 16'd16, 32'h100, 32'h400, 1'b1, 1'b0);
    chk("R5", "dst line bad cfg", {28'd0, status_o}, 32'h8);
    chk("R5", "no access dst", n_rd + n_wr, 0);
    clear_all();

    // R6 counts
    run(2'b01, 2'b00, 16'd6, 32'h100, 32'h400, 1'b1, 1'b1);
    chk("R6", "count not multiple", {28'd0, status_o}, 32'h8);
    chk("R6", "no access", n_rd + n_wr, 0);
    clear_all();
    run(2'b01, 2'b01, 16'd0, 32'h100, 32'h400, 1'b1, 1'b1);
    chk("R6", "zero count", {28'd0, status_o}, 32'h8);
    clear_all();

    // R7 misaligned start
    run(2'b00, 2'b00, 16'd8, 32'h102, 32'h400, 1'b1, 1'b1);
    chk("R7", "misaligned src", {28'd0, status_o}, 32'h4);
    chk("R7", "no access", n_rd + n_wr, 0);
    clear_all();
    run(2'b01, 2'b11, 16'd16, 32'h100, 32'h408, 1'b1, 1'b1);
    chk("R7", "misaligned dst line", {28'd0, status_o}, 32'h4);
    clear_all();

    // R8 bus fault on write, then on read
    err_on = 1'b1; err_addr = 32'h408;
    run(2'b00, 2'b00, 16'd16, 32'h100, 32'h400, 1'b1, 1'b1);
    chk("R8", "fault status", {28'd0, status_o}, 32'h2);
    chk("R8", "busy dropped", {31'd0, busy_o}, 32'd0);
    chk("R8", "src ptr", src_ptr_o, 32'h10c);
    chk("R8", "dst ptr at failing write", dst_ptr_o, 32'h408);
    clear_all();
    err_addr = 32'h104;
    run(2'b00, 2'b00, 16'd16, 32'h100, 32'h400, 1'b1, 1'b1);
    chk("R8", "src ptr at failing read", src_ptr_o, 32'h104);
    chk("R8", "dst ptr read fault", dst_ptr_o, 32'h404);
    err_on = 1'b0;
    clear_all();

    // R10 masking, R11 clear
    run(2'b01, 2'b01, 16'd0, 32'h100, 32'h400, 1'b1, 1'b1);
    irq_en_i = 4'h0; #1;
    chk("R10", "irq all disabled", {31'd0, irq_o}, 32'd0);
    irq_en_i = 4'b0111; #1;
    chk("R10", "irq other enables", {31'd0, irq_o}, 32'd0);
    irq_en_i = 4'b1000; #1;
    chk("R10", "irq matching enable", {31'd0, irq_o}, 32'd1);
    @(negedge clk_i);
    stat_clr_i = 4'b0111;
    @(negedge clk_i);
    stat_clr_i = 4'b0000;
    chk("R11", "clear of other bits", {28'd0, status_o}, 32'h8);
    @(negedge clk_i);
    chk("R11", "zero write keeps", {28'd0, status_o}, 32'h8);
    stat_clr_i = 4'b1000;
    @(negedge clk_i);
    stat_clr_i = 4'b0000;
    chk("R11", "write one clears", {28'd0, status_o}, 32'h0);
    chk("R10", "irq after clear", {31'd0, irq_o}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule